// File: doc/BRIEF.md
# Indirect Table Access Engine

This block gives a host processor indirect access to three internal lookup tables: a small per-instance spanning-tree state table, a hashed layer-2 SRAM and a small layer-2 CAM. The host first writes up to four 32-bit data words. It then writes a command word that carries an execute flag, a direction flag, a table selector and an entry index.

While the access runs, the engine holds the execute flag high. It drops the flag once the entry has been written, or once it has been fetched into the data words. The host polls the command word until the flag reads zero and then collects any read result.

There are two command layouts, and both share the one handshake. The generic layout reaches the spanning-tree table with four-word entries. The layer-2 layout reaches the SRAM and the CAM with three-word entries. The SRAM index is formed by the host as a hash value shifted left by two, joined with a slot number in a four-entry bucket.

Top module: `tbl_access_engine`

## Requirements
- R1: Every accepted host read returns its data one cycle later, with `host_rvalid` high in that cycle. `host_ready` is always high. Word addresses 0 to 3 are the data words, and they read back what the host last wrote. Address 4 is the generic command word, address 5 is the layer-2 command word and address 6 is status. Status bit 0 is the collision flag and bit 1 is busy.
- R2: Generic command layout:
  - bit 16 is execute;
  - bit 15 is 1 for a write and 0 for a read;
  - bits 14:12 are the table type;
  - bits 11:0 are the index.
  Type 5 selects the spanning-tree table of `STP_DEPTH` entries. An entry is 128 bits, with data word 0 as the least significant 32 bits.
- R3: Layer-2 command layout:
  - bit 17 is execute;
  - bit 16 is 1 for a write and 0 for a read;
  - bits 15:14 are the type;
  - bits 13:0 are the index.
  Type 0 selects the hashed SRAM of `SRAM_DEPTH` entries, at index (hash << 2) | slot. An entry is 96 bits held in data words 0 to 2, and a layer-2 read clears data word 3.
- R4: The execute bit reads as 1 for exactly `LAT` cycles after the command edge and reads as 0 afterwards. A read result is in the data words once the execute bit has cleared. At most one command is in progress at any time.
- R5: Layer-2 type 1 selects the CAM. Only index bits 5:0 are decoded, so indices that differ above bit 5 name the same entry.
- R6: An index at or beyond the depth of the selected table changes no memory, and a read of it returns all-zero data. An unknown type behaves the same way: generic types other than 5, and layer-2 types 2 and 3.
- R7: A write to either command word while a command is in progress is ignored and sets the sticky collision flag. Writing status with bit 0 set clears the flag.
- R8: After reset the data words, both command words and the status read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Request accepted (always high) |
| host_write | input | 1 | 1 for a register write, 0 for a read |
| host_addr | input | 3 | Word address |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |

## Verification
The assertions assume a well-behaved host:
- it never writes a data word while a command is in progress;
- it raises `host_valid` for single cycles, with all request fields settled before the clock edge.

The bench issues every request from a task that holds each field for one full cycle. It loads the data words only after polling has shown that the previous command has finished. The only commands it issues during the busy window are the deliberate collisions.

// File: rtl/tbl_access_engine.sv
module tbl_access_engine #(
  parameter int LAT        = 2,
  parameter int STP_DEPTH  = 16,
  parameter int SRAM_DEPTH = 64,
  parameter int CAM_DEPTH  = 64,
  parameter int STP_TYPE   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  output logic        host_ready,
  input  logic        host_write,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic        host_rvalid,
  output logic [31:0] host_rdata
);
  localparam int CW  = $clog2(LAT + 1);
  localparam int SAW = $clog2(STP_DEPTH);
  localparam int RAW = $clog2(SRAM_DEPTH);
  localparam int CAW = $clog2(CAM_DEPTH);
  localparam logic [11:0]   STP_LIM  = 12'(STP_DEPTH);
  localparam logic [14:0]   SRAM_LIM = 15'(SRAM_DEPTH);
  localparam logic [6:0]    CAM_LIM  = 7'(CAM_DEPTH);
  localparam logic [2:0]    STP_CODE = 3'(STP_TYPE);
  localparam logic [CW-1:0] LAST     = CW'(LAT - 1);

  logic [31:0]  dw [4];
  logic [15:0]  gcmd;
  logic [16:0]  lcmd;
  logic         gen_act, l2_act, coll, busy;
  logic [CW-1:0] cnt;

  logic [127:0] stp_mem  [STP_DEPTH];
  logic [95:0]  sram_mem [SRAM_DEPTH];
  logic [95:0]  cam_mem  [CAM_DEPTH];

  logic wr_acc, cmd_wr, done, stp_hit, sram_hit, cam_hit, rd_done;
  logic [127:0] result;
  logic [31:0]  rmux;
  logic [SAW-1:0] sidx;
  logic [RAW-1:0] ridx;
  logic [CAW-1:0] cidx;

  assign host_ready = 1'b1;
  assign busy     = gen_act | l2_act;
  assign wr_acc   = host_valid & host_write;
  assign cmd_wr   = wr_acc & (host_addr == 3'd4 || host_addr == 3'd5);
  assign done     = busy && cnt == LAST;

  assign stp_hit  = gcmd[14:12] == STP_CODE && gcmd[11:0] < STP_LIM;
  assign sram_hit = lcmd[15:14] == 2'd0 && {1'b0, lcmd[13:0]} < SRAM_LIM;
  assign cam_hit  = lcmd[15:14] == 2'd1 && {1'b0, lcmd[5:0]} < CAM_LIM;
  assign sidx     = gcmd[SAW-1:0];
  assign ridx     = lcmd[RAW-1:0];
  assign cidx     = lcmd[CAW-1:0];
  assign rd_done  = done && ((gen_act && !gcmd[15]) || (l2_act && !lcmd[16]));

  always_comb begin
    result = '0;
    if (gen_act) begin
      if (stp_hit) result = stp_mem[sidx];
    end else if (sram_hit) begin
      result = {32'b0, sram_mem[ridx]};
    end else if (cam_hit) begin
      result = {32'b0, cam_mem[cidx]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_act <= 1'b0;
      l2_act  <= 1'b0;
      coll    <= 1'b0;
      cnt     <= '0;
      gcmd    <= '0;
      lcmd    <= '0;
    end else begin
      if (cmd_wr && busy)
        coll <= 1'b1;
      else if (wr_acc && host_addr == 3'd6 && host_wdata[0])
        coll <= 1'b0;
      if (wr_acc && host_addr == 3'd4 && !busy) begin
        gcmd    <= host_wdata[15:0];
        gen_act <= host_wdata[16];
        cnt     <= '0;
      end
      if (wr_acc && host_addr == 3'd5 && !busy) begin
        lcmd   <= host_wdata[16:0];
        l2_act <= host_wdata[17];
        cnt    <= '0;
      end
      if (busy) begin
        if (done) begin
          gen_act <= 1'b0;
          l2_act  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done && gen_act && gcmd[15] && stp_hit)
      stp_mem[sidx] <= {dw[3], dw[2], dw[1], dw[0]};
    if (done && l2_act && lcmd[16] && sram_hit)
      sram_mem[ridx] <= {dw[2], dw[1], dw[0]};
    if (done && l2_act && lcmd[16] && cam_hit)
      cam_mem[cidx] <= {dw[2], dw[1], dw[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 4; w++) dw[w] <= '0;
    end else if (rd_done) begin
      for (int w = 0; w < 4; w++) dw[w] <= result[32*w +: 32];
    end else if (wr_acc && !host_addr[2]) begin
      dw[host_addr[1:0]] <= host_wdata;
    end
  end

  always_comb begin
    case (host_addr)
      3'd0, 3'd1, 3'd2, 3'd3: rmux = dw[host_addr[1:0]];
      3'd4:    rmux = {15'b0, gen_act, gcmd};
      3'd5:    rmux = {14'b0, l2_act, lcmd};
      3'd6:    rmux = {30'b0, busy, coll};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_valid & ~host_write;
      if (host_valid && !host_write) host_rdata <= rmux;
    end
  end
endmodule

// File: rtl/tbl_access_engine_chk.sv
module tbl_access_engine_chk #(
  parameter int LAT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_valid,
  input logic        host_write,
  input logic [2:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic        host_rvalid,
  input logic        gen_act,
  input logic        l2_act,
  input logic        coll
);
  localparam int BW = $clog2(LAT + 2);
  logic busy;
  logic [BW-1:0] bcnt;
  assign busy = gen_act | l2_act;

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < BW'(LAT));
  a_r4_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == BW'(LAT));
  a_r4_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gen_act, l2_act}));
  a_r7_coll_set: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_write && (host_addr == 3'd4 || host_addr == 3'd5) && busy) |=> coll);
  a_r7_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !(host_valid && host_write && host_addr == 3'd6 && host_wdata[0])) |=> coll);
  a_r1_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write) |=> host_rvalid);
  a_r1_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && !host_write) |=> !host_rvalid);
endmodule

bind tbl_access_engine tbl_access_engine_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
  .gen_act(gen_act), .l2_act(l2_act), .coll(coll)
);

// File: tb/tbl_access_engine_test.sv
`timescale 1ns/1ps
module tbl_access_engine_test;
  localparam int LAT = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [2:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_ready, host_rvalid;
  logic [31:0] host_rdata;
  int errors = 0, checks = 0;
  bit finished = 0;

  tbl_access_engine uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(int t, int i, int w);
    return {t[7:0], i[7:0], w[7:0], 8'h5A} ^ (32'(i) * 32'h01030507);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    host_valid = 1'b1; host_write = 1'b0; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
    checks++;
    if (!host_rvalid) begin
      errors++;
      $display("FAIL R1 actual=rvalid 0 expected=rvalid 1");
    end
    d = host_rdata;
  endtask

  task automatic run(logic [2:0] a, logic [31:0] word, output int polls);
    logic [31:0] v;
    int bitn;
    bitn = (a == 3'd4) ? 16 : 17;
    wr(a, word);
    polls = 0;
    for (int k = 0; k < 40; k++) begin
      rd(a, v);
      if (!v[bitn]) break;
      polls++;
    end
  endtask

  function automatic logic [31:0] gcmd(bit w, int t, int idx);
    return (32'd1 << 16) | (32'(w) << 15) | (32'(t & 7) << 12) | 32'(idx & 12'hfff);
  endfunction

  function automatic logic [31:0] lcmd(bit w, int t, int idx);
    return (32'd1 << 17) | (32'(w) << 16) | (32'(t & 3) << 14) | 32'(idx & 14'h3fff);
  endfunction

  task automatic load(int t, int i, int n);
    for (int w = 0; w < 4; w++) wr(3'(w), (w < n) ? pat(t, i, w) : 32'hDEAD0000);
  endtask

  task automatic expect_words(string req, int t, int i, int n, bit zero);
    logic [31:0] v;
    for (int w = 0; w < 4; w++) begin
      rd(3'(w), v);
      chk(req, v, (zero || w >= n) ? 32'h0 : pat(t, i, w));
    end
  endtask

  initial begin
    int p;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R8", v, 32'h0);
    end
    // R1 data words
    for (int w = 0; w < 4; w++) wr(3'(w), pat(9, 9, w));
    for (int w = 0; w < 4; w++) begin
      rd(3'(w), v);
      chk("R1", v, pat(9, 9, w));
    end
    rd(3'd7, v);
    chk("R1", v, 32'h0);
    // R2 spanning-tree table sweep, R4 busy window
    for (int i = 0; i < 16; i++) begin
      load(1, i, 4);
      run(3'd4, gcmd(1, 5, i), p);
      chk("R4", 32'(p), 32'(LAT));
    end
    for (int i = 0; i < 16; i++) begin
      load(7, 0, 0);
      run(3'd4, gcmd(0, 5, i), p);
      chk("R4", 32'(p), 32'(LAT));
      expect_words("R2", 1, i, 4, 0);
    end
    rd(3'd4, v);
    chk("R2", v, gcmd(0, 5, 15) & ~(32'd1 << 16));
    // R3 hashed SRAM sweep
    for (int h = 0; h < 16; h++)
      for (int s = 0; s < 4; s++) begin
        load(2, (h << 2) | s, 3);
        run(3'd5, lcmd(1, 0, (h << 2) | s), p);
      end
    for (int h = 0; h < 16; h++)
      for (int s = 0; s < 4; s++) begin
        load(7, 1, 4);
        run(3'd5, lcmd(0, 0, (h << 2) | s), p);
        chk("R4", 32'(p), 32'(LAT));
        expect_words("R3", 2, (h << 2) | s, 3, 0);
      end
    rd(3'd5, v);
    chk("R3", v, lcmd(0, 0, 63) & ~(32'd1 << 17));
    // R5 CAM sweep and index aliasing
    for (int i = 0; i < 64; i++) begin
      load(3, i, 3);
      run(3'd5, lcmd(1, 1, i), p);
    end
    for (int i = 0; i < 64; i++) begin
      load(7, 2, 0);
      run(3'd5, lcmd(0, 1, i), p);
      expect_words("R5", 3, i, 3, 0);
    end
    load(4, 5, 3);
    run(3'd5, lcmd(1, 1, 64 + 5), p);
    load(7, 3, 0);
    run(3'd5, lcmd(0, 1, 5), p);
    expect_words("R5", 4, 5, 3, 0);
    run(3'd5, lcmd(0, 1, 1024 + 5), p);
    expect_words("R5", 4, 5, 3, 0);
    // R6 out of range and unknown types
    load(5, 64, 3);
    run(3'd5, lcmd(1, 0, 64), p);
    load(7, 4, 4);
    run(3'd5, lcmd(0, 0, 64), p);
    expect_words("R6", 0, 0, 0, 1);
    run(3'd5, lcmd(0, 0, 0), p);
    expect_words("R6", 2, 0, 3, 0);
    load(7, 5, 4);
    run(3'd5, lcmd(0, 2, 3), p);
    expect_words("R6", 0, 0, 0, 1);
    load(7, 5, 4);
    run(3'd5, lcmd(0, 3, 3), p);
    expect_words("R6", 0, 0, 0, 1);
    load(7, 6, 4);
    run(3'd4, gcmd(0, 3, 0), p);
    expect_words("R6", 0, 0, 0, 1);
    load(6, 16, 4);
    run(3'd4, gcmd(1, 5, 16), p);
    run(3'd4, gcmd(0, 5, 16), p);
    expect_words("R6", 0, 0, 0, 1);
    run(3'd4, gcmd(0, 5, 0), p);
    expect_words("R6", 1, 0, 4, 0);
    // R7 collision
    load(8, 1, 3);
    wr(3'd5, lcmd(1, 0, 1));
    wr(3'd5, lcmd(1, 0, 2));
    rd(3'd6, v);
    chk("R7", v, 32'h3);
    run(3'd5, lcmd(0, 0, 1), p);
    expect_words("R7", 8, 1, 3, 0);
    run(3'd5, lcmd(0, 0, 2), p);
    expect_words("R7", 2, 2, 3, 0);
    rd(3'd6, v);
    chk("R7", v, 32'h1);
    wr(3'd6, 32'h0);
    rd(3'd6, v);
    chk("R7", v, 32'h1);
    wr(3'd6, 32'h1);
    rd(3'd6, v);
    chk("R7", v, 32'h0);
    load(8, 7, 4);
    wr(3'd5, lcmd(0, 1, 9));
    wr(3'd4, gcmd(1, 5, 7));
    rd(3'd6, v);
    chk("R7", v, 32'h3);
    rd(3'd6, v);
    chk("R4", v, 32'h1);
    run(3'd4, gcmd(0, 5, 7), p);
    expect_words("R7", 1, 7, 4, 0);
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule